// File: doc/BRIEF.md
# Message-signalled interrupt vector table controller

This block keeps a small table of interrupt vectors and a pending-bit array behind a dword register port, and turns vector raise events into outgoing memory-write requests. Each table entry carries a 64-bit message address, a 32-bit message data word and a control word whose bit 0 masks that vector. A function-wide mask input masks every vector at once.

When an in-use, in-range vector is raised while unmasked, the block queues one write of the entry's data to the entry's address and sends it on a valid/ready request port. When the vector is masked, the block instead sets the vector's pending bit. Once a pending vector becomes unmasked, the pending bit is cleared and the message is sent. Vectors waiting to be sent are issued lowest index first, one request at a time.

Top module: `msix_vec_ctrl`

## Requirements
- R1: After reset every address and data dword of the table reads 0, every control dword reads 1 (mask set), the pending array reads 0, and msg_valid is low.
- R2: Entry e occupies register offsets 16e..16e+15 with dword 0 = address bits 31:0, dword 1 = address bits 63:32, dword 2 = data, dword 3 = control; only control bit 0 is stored (other bits read 0); offset bits 1:0 are ignored; reg_rdata holds the addressed dword from the cycle after a reg_rd strobe.
- R3: Raising an unmasked vector that is in range and marked in use produces exactly one request with msg_addr = {dword 1, dword 0} and msg_data = dword 2 of that entry.
- R4: A raise whose vector number is not below NUM_VEC, or whose vec_in_use bit is clear, produces no request and sets no pending bit.
- R5: A vector is masked when func_mask is 1 or its control bit 0 is 1; raising a masked vector sets its pending bit and produces no request.
- R6: The pending array is read at offsets with reg_addr bit REG_AW-1 set; dword k bit j reports vector 32k+j; writes to that region have no effect.
- R7: When a vector with its pending bit set becomes unmasked, its pending bit clears and one request for that vector is produced.
- R8: While msg_valid is high and msg_ready is low, msg_valid, msg_addr and msg_data hold; the message content is captured when the request is launched, so later table writes do not alter it.
- R9: Vectors waiting to be sent are issued lowest vector number first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| func_mask | input | 1 | Function-wide mask |
| vec_in_use | input | NUM_VEC | Per-vector in-use flags |
| raise | input | 1 | Vector raise strobe |
| raise_vec | input | VEC_W | Number of the vector being raised |
| msg_valid | output | 1 | Outgoing write request valid |
| msg_ready | input | 1 | Outgoing write request accepted |
| msg_addr | output | 64 | Write address of the request |
| msg_data | output | 32 | Write data of the request |

## Verification
The hardest state to reach is several vectors waiting at once while a launched request is still held, since an accepting sink drains each message a few cycles after its raise. The bench holds msg_ready low, raises three vectors out of numeric order and rewrites the held vector's data word, then releases msg_ready; the scoreboard expects the held message with its old content followed by the others in ascending order. Pending replay is reached by raising under the function mask and under a per-vector mask, then clearing each in turn.

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl #(
  parameter int NUM_VEC = 8,
  parameter int VEC_W   = 8,
  parameter int REG_AW  = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                func_mask,
  input  logic [NUM_VEC-1:0]  vec_in_use,
  input  logic                raise,
  input  logic [VEC_W-1:0]    raise_vec,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [63:0]         msg_addr,
  output logic [31:0]         msg_data
);

  localparam int IDX_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
  localparam int EW     = REG_AW - 5;
  localparam int PW     = REG_AW - 3;
  localparam int PBA_DW = (NUM_VEC + 31) / 32;

  logic [31:0] t_lo  [NUM_VEC];
  logic [31:0] t_hi  [NUM_VEC];
  logic [31:0] t_dat [NUM_VEC];
  logic [NUM_VEC-1:0] t_msk, pend, armed, masked, replay, raise_hot, launch_hot;
  logic [PBA_DW*32-1:0] pend_pad;
  logic [31:0] rd_mux;
  logic [IDX_W-1:0] sel;
  logic raise_ok, go, unused_lsb;

  wire          pba_sel = reg_addr[REG_AW-1];
  wire [EW-1:0] ent     = reg_addr[REG_AW-2:4];
  wire [1:0]    wsel    = reg_addr[3:2];
  wire [PW-1:0] pidx    = reg_addr[REG_AW-2:2];

  assign unused_lsb = ^reg_addr[1:0];
  assign pend_pad   = (PBA_DW*32)'(pend);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < NUM_VEC; e++) begin
        t_lo[e]  <= '0;
        t_hi[e]  <= '0;
        t_dat[e] <= '0;
      end
      t_msk <= '1;
    end else if (reg_wr && !pba_sel) begin
      for (int e = 0; e < NUM_VEC; e++) begin
        if (ent == EW'(e)) begin
          case (wsel)
            2'd0: t_lo[e]  <= reg_wdata;
            2'd1: t_hi[e]  <= reg_wdata;
            2'd2: t_dat[e] <= reg_wdata;
            default: t_msk[e] <= reg_wdata[0];
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (pba_sel) begin
      for (int k = 0; k < PBA_DW; k++)
        if (pidx == PW'(k)) rd_mux = pend_pad[k*32 +: 32];
    end else begin
      for (int e = 0; e < NUM_VEC; e++) begin
        if (ent == EW'(e)) begin
          case (wsel)
            2'd0: rd_mux = t_lo[e];
            2'd1: rd_mux = t_hi[e];
            2'd2: rd_mux = t_dat[e];
            default: rd_mux = {31'b0, t_msk[e]};
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assign masked    = t_msk | {NUM_VEC{func_mask}};
  assign raise_ok  = raise && (raise_vec < VEC_W'(NUM_VEC)) && vec_in_use[raise_vec[IDX_W-1:0]];
  assign raise_hot = raise_ok ? (NUM_VEC'(1) << raise_vec[IDX_W-1:0]) : '0;
  assign replay    = pend & ~masked;
  assign go        = !msg_valid && (|armed);

  always_comb begin
    sel = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--)
      if (armed[i]) sel = IDX_W'(i);
  end

  assign launch_hot = go ? (NUM_VEC'(1) << sel) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= '0;
      armed <= '0;
    end else begin
      pend  <= (pend & ~replay) | (raise_hot & masked);
      armed <= (armed & ~launch_hot) | (raise_hot & ~masked) | replay;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (msg_valid && msg_ready) begin
      msg_valid <= 1'b0;
    end else if (go) begin
      msg_valid <= 1'b1;
      msg_addr  <= {t_hi[sel], t_lo[sel]};
      msg_data  <= t_dat[sel];
    end
  end

endmodule

// File: rtl/msix_vec_ctrl_chk.sv
module msix_vec_ctrl_chk #(
  parameter int NV = 8,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          raise,
  input logic [VW-1:0] raise_vec,
  input logic          msg_valid,
  input logic          msg_ready,
  input logic [63:0]   msg_addr,
  input logic [31:0]   msg_data,
  input logic [NV-1:0] pend
);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !msg_valid); // R1

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data)); // R8

  AST_TAKEN_DROPS: assert property (@(posedge clk) disable iff (rst)
    msg_valid && msg_ready |=> !msg_valid); // R8

  AST_PEND_NEEDS_RAISE: assert property (@(posedge clk) disable iff (rst)
    (|(pend & ~$past(pend))) |-> $past(raise && (raise_vec < VW'(NV)))); // R4

  AST_PEND_ONE_NEW: assert property (@(posedge clk) disable iff (rst)
    $countones(pend & ~$past(pend)) <= 1); // R5

endmodule

bind msix_vec_ctrl msix_vec_ctrl_chk #(.NV(NUM_VEC), .VW(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .raise(raise), .raise_vec(raise_vec),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
  .msg_data(msg_data), .pend(pend)
);

// File: tb/sim_msix_vec_ctrl.sv
`timescale 1ns/1ps
module sim_msix_vec_ctrl;
  localparam int NV = 8;
  localparam int AW = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic func_mask = 0;
  logic [NV-1:0] vec_in_use = 8'hBF;
  logic raise = 0;
  logic [7:0] raise_vec = '0;
  logic msg_valid, msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  msix_vec_ctrl #(.NUM_VEC(NV), .VEC_W(8), .REG_AW(AW)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .func_mask(func_mask),
    .vec_in_use(vec_in_use), .raise(raise), .raise_vec(raise_vec),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, rx_cnt = 0;
  logic [95:0] exp_q[$];
  string tag_q[$];
  logic [31:0] lo_m[NV], hi_m[NV], dat_m[NV];

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && msg_valid && msg_ready) begin
      rx_cnt++;
      if (exp_q.size() == 0) chk(0, "R4/R5 unexpected request", {msg_addr, msg_data}, '0);
      else begin
        logic [95:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({msg_addr, msg_data} == e, t, {msg_addr, msg_data}, e);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic fire(input logic [7:0] v);
    @(negedge clk); raise = 1; raise_vec = v;
    @(negedge clk); raise = 0;
  endtask

  task automatic expect_msg(input int v, input string t);
    exp_q.push_back({hi_m[v], lo_m[v], dat_m[v]});
    tag_q.push_back(t);
  endtask

  task automatic drain();
    for (int i = 0; i < 60 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 queue drained", 96'(exp_q.size()), '0);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(msg_valid == 0, "R1 valid after reset", 96'(msg_valid), 0);
    rd(12'h000, d); chk(d == 0, "R1 entry0 addr lo", 96'(d), 0);
    rd(12'h008, d); chk(d == 0, "R1 entry0 data", 96'(d), 0);
    rd(12'h07C, d); chk(d == 1, "R1 entry7 control", 96'(d), 1);
    rd(12'h800, d); chk(d == 0, "R1 pending array", 96'(d), 0);

    for (int v = 0; v < NV; v++) begin
      lo_m[v] = 32'h1000_0000 + v * 16; hi_m[v] = 32'hA0 + v; dat_m[v] = 32'hD000 + v;
      wr(AW'(v * 16),     lo_m[v]);
      wr(AW'(v * 16 + 4), hi_m[v]);
      wr(AW'(v * 16 + 8), dat_m[v]);
    end
    rd(12'h03B, d); chk(d == dat_m[3], "R2 data dword with offset lsbs set", 96'(d), 96'(dat_m[3]));
    wr(12'h01C, 32'hFFFF_FFFE);
    rd(12'h01C, d); chk(d == 0, "R2 control only bit0 stored", 96'(d), 0);

    base = rx_cnt;
    expect_msg(1, "R3 unmasked vector request");
    fire(1);
    drain();
    chk(rx_cnt - base == 1, "R3 exactly one request", 96'(rx_cnt - base), 1);

    base = rx_cnt;
    fire(8); fire(200); fire(6);
    repeat (6) @(negedge clk);
    chk(rx_cnt == base, "R4 ignored raises send nothing", 96'(rx_cnt - base), 0);
    rd(12'h800, d); chk(d == 0, "R4 ignored raises leave no pending", 96'(d), 0);

    fire(2);
    repeat (3) @(negedge clk);
    rd(12'h800, d); chk(d == 32'h4, "R5 vector mask sets pending", 96'(d), 4);
    func_mask = 1;
    fire(1);
    repeat (3) @(negedge clk);
    rd(12'h800, d); chk(d == 32'h6, "R5 function mask sets pending", 96'(d), 6);
    chk(rx_cnt == base, "R5 masked raises send nothing", 96'(rx_cnt - base), 0);
    wr(12'h800, 32'hFF);
    rd(12'h800, d); chk(d == 32'h6, "R6 pending array write ignored", 96'(d), 6);

    expect_msg(1, "R7 replay on function unmask");
    @(negedge clk); func_mask = 0;
    drain();
    rd(12'h800, d); chk(d == 32'h4, "R7 replayed bit cleared", 96'(d), 4);
    expect_msg(2, "R7 replay on vector unmask");
    wr(12'h02C, 32'h0);
    drain();
    rd(12'h800, d); chk(d == 0, "R7 pending empty", 96'(d), 0);

    wr(12'h03C, 0); wr(12'h04C, 0); wr(12'h05C, 0);
    base = rx_cnt;
    @(negedge clk); msg_ready = 0;
    expect_msg(1, "R8 held message keeps old content");
    fire(1);
    repeat (3) @(negedge clk);
    chk(msg_valid && msg_data == dat_m[1], "R8 held while not ready", {msg_addr, msg_data}, {hi_m[1], lo_m[1], dat_m[1]});
    wr(12'h018, 32'hBEEF);
    expect_msg(3, "R9 order first");
    expect_msg(4, "R9 order second");
    expect_msg(5, "R9 order third");
    fire(5); fire(3); fire(4);
    repeat (4) @(negedge clk);
    chk(msg_valid && msg_addr == {hi_m[1], lo_m[1]} && msg_data == dat_m[1], "R8 stable after table write",
        {msg_addr, msg_data}, {hi_m[1], lo_m[1], dat_m[1]});
    msg_ready = 1;
    drain();
    chk(rx_cnt - base == 4, "R9 all waiting vectors sent", 96'(rx_cnt - base), 4);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R3 no missing requests", 96'(exp_q.size()), 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule